// File: doc/BRIEF.md
# SIMD Field Interleave and Even/Odd Gather Unit

This block rearranges the fields of two 128-bit source words without changing any field value. Each source is split into equal fields. The field width is chosen per request, from 1 bit up to 64 bits, in powers of two. Four operations are available. Two of them interleave one half of the fields of the first source with the same half of the second. The other two take every second field of the pair of sources, viewed as one double-length word. The interleave operations are the exact inverse of the gather operations, so a pair of gathers followed by a pair of interleaves gives back the original sources.

A request is presented on one cycle with a valid strobe, an operation code and a field-size code. The result appears in a register on the next cycle, with its own valid flag. Narrow fields of 1, 2 and 4 bits are produced in one pass, using the same datapath as the byte-sized and wider fields.

Top module: `fieldmix_unit`

## Requirements
- R1: Operation code 00 (low interleave): with N fields per source and field 0 at the least significant end, result field 2j equals field j of `src_a` and result field 2j+1 equals field j of `src_b`, for j from 0 to N/2-1.
- R2: Operation code 01 (high interleave): result field 2j equals field j+N/2 of `src_a` and result field 2j+1 equals field j+N/2 of `src_b`, for j from 0 to N/2-1.
- R3: Operation code 10 (even gather): the 2N fields of the joined word {`src_b`,`src_a`} are numbered 0 to 2N-1, with `src_a` holding fields 0 to N-1. Result field j equals joined field 2j.
- R4: Operation code 11 (odd gather): result field j equals joined field 2j+1, the upper half of each double-width field of the joined word.
- R5: Size codes 0 to 6 select field widths of 1, 2, 4, 8, 16, 32 and 64 bits, all produced in a single pass.
- R6: Size code 7 is reserved. A request with it yields an all-zero result word, which still carries a valid flag.
- R7: `out_valid` is `in_valid` delayed by exactly one clock cycle, and a result is visible in the cycle after its request.
- R8: While `in_valid` is low, `out_data` keeps its previous value whatever the other inputs do.
- R9: During reset and right after it, `out_valid` is 0 and `out_data` is all zero.
- R10: For every field size, applying codes 00 and 01 to the results of codes 10 and 11 (even result as `src_a`, odd result as `src_b`) gives back the original `src_a` and `src_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Operation code (see R1 to R4) |
| in_size | input | 3 | Field-size code (see R5, R6) |
| src_a | input | 128 | First source word |
| src_b | input | 128 | Second source word |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_data | output | 128 | Registered result word |

## Verification
Two things can happen in the same cycle: a new request can be accepted while the result of the previous one is on the output. This happens when requests come back to back. The bench issues an even gather and then an odd gather on consecutive cycles with different field sizes. It checks that each result appears in its own cycle and matches the reference for its own operation and size, with no mix-up between the two. It also checks that a pause after a request keeps the result stable.

// File: rtl/fm_pkg.sv
package fm_pkg;
  // Operation codes; the bit pattern is part of the external contract.
  typedef enum logic [1:0] {
    OP_MRG_LO = 2'b00,
    OP_MRG_HI = 2'b01,
    OP_PCK_LO = 2'b10,
    OP_PCK_HI = 2'b11
  } fm_op_e;

  // Number of legal field-size codes (widths 2**0 .. 2**6).
  localparam int unsigned NSZ = 7;
  localparam logic [2:0]  SZ_RESERVED = 3'd7;
  localparam int unsigned NOPS = 4;
endpackage

// File: rtl/fm_size_slice.sv
// All four rearrangements for one fixed field width of 2**LOG_W bits.
module fm_size_slice #(
  parameter int unsigned REG_W = 128,
  parameter int unsigned LOG_W = 0
) (
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] mrg_lo,
  output logic [REG_W-1:0] mrg_hi,
  output logic [REG_W-1:0] pck_lo,
  output logic [REG_W-1:0] pck_hi
);
  localparam int unsigned FW = 1 << LOG_W;
  localparam int unsigned NF = REG_W / FW;
  localparam int unsigned IW = $clog2(REG_W);
  localparam int unsigned CW = IW + 1;

  // Result field f: even f from src_a, odd f from src_b, source field f/2
  // shifted by half the field count for the upper variant.
  function automatic logic [REG_W-1:0] interleave(
    input logic [REG_W-1:0] a,
    input logic [REG_W-1:0] b,
    input bit               upper
  );
    logic [REG_W-1:0] r;
    int f;
    int src;
    for (int p = 0; p < REG_W; p++) begin
      f   = p / FW;
      src = (f / 2) + (upper ? int'(NF / 2) : 0);
      if (f % 2 == 1) r[p] = b[IW'(src * FW + (p % FW))];
      else            r[p] = a[IW'(src * FW + (p % FW))];
    end
    return r;
  endfunction

  // Result field f: joined field 2f (even) or 2f+1 (odd) of {b,a}.
  function automatic logic [REG_W-1:0] gather(
    input logic [REG_W-1:0] a,
    input logic [REG_W-1:0] b,
    input bit               odd
  );
    logic [2*REG_W-1:0] cat;
    logic [REG_W-1:0]   r;
    int idx;
    cat = {b, a};
    for (int p = 0; p < REG_W; p++) begin
      idx  = (2 * (p / FW) + (odd ? 1 : 0)) * FW + (p % FW);
      r[p] = cat[CW'(idx)];
    end
    return r;
  endfunction

  always_comb begin
    mrg_lo = interleave(src_a, src_b, 1'b0);
    mrg_hi = interleave(src_a, src_b, 1'b1);
    pck_lo = gather(src_a, src_b, 1'b0);
    pck_hi = gather(src_a, src_b, 1'b1);
  end
endmodule

// File: rtl/fm_select.sv
// Picks one candidate by size code and operation; reserved size gives zero.
module fm_select
  import fm_pkg::*;
#(
  parameter int unsigned REG_W = 128
) (
  input  logic [NSZ-1:0][NOPS-1:0][REG_W-1:0] cand,
  input  logic [1:0]                          op,
  input  logic [2:0]                          size,
  output logic                                size_ok,
  output logic [REG_W-1:0]                    sel_word
);
  always_comb begin
    size_ok  = (size != SZ_RESERVED);
    sel_word = '0;
    if (size_ok) sel_word = cand[size][op];
  end
endmodule

// File: rtl/fm_out_reg.sv
// Result register: loads on a request, holds otherwise.
module fm_out_reg #(
  parameter int unsigned REG_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [REG_W-1:0] d,
  output logic             q_valid,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load_en;
      if (load_en) q <= d;
    end
  end
endmodule

// File: rtl/fieldmix_unit.sv
// Top: one slice per field width, a selector and the output register.
// REG_W must be a power of two of at least 128 so the widest field fits twice.
module fieldmix_unit
  import fm_pkg::*;
#(
  parameter int unsigned REG_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_op,
  input  logic [2:0]       in_size,
  input  logic [REG_W-1:0] src_a,
  input  logic [REG_W-1:0] src_b,
  output logic             out_valid,
  output logic [REG_W-1:0] out_data
);
  logic [NSZ-1:0][NOPS-1:0][REG_W-1:0] cand;
  logic [REG_W-1:0]                    sel_word;
  logic                                size_ok;
  logic                                load_en;

  assign load_en = in_valid;

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    fm_size_slice #(.REG_W(REG_W), .LOG_W(s)) u_slice (
      .src_a  (src_a),
      .src_b  (src_b),
      .mrg_lo (cand[s][OP_MRG_LO]),
      .mrg_hi (cand[s][OP_MRG_HI]),
      .pck_lo (cand[s][OP_PCK_LO]),
      .pck_hi (cand[s][OP_PCK_HI])
    );
  end

  fm_select #(.REG_W(REG_W)) u_sel (
    .cand     (cand),
    .op       (in_op),
    .size     (in_size),
    .size_ok  (size_ok),
    .sel_word (sel_word)
  );

  fm_out_reg #(.REG_W(REG_W)) u_oreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (load_en),
    .d       (sel_word),
    .q_valid (out_valid),
    .q       (out_data)
  );
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int unsigned REG_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [1:0]       in_op,
  input logic [2:0]       in_size,
  input logic [REG_W-1:0] src_a,
  input logic [REG_W-1:0] src_b,
  input logic             out_valid,
  input logic [REG_W-1:0] out_data,
  input logic [REG_W-1:0] sel_word,
  input logic             size_ok
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R7
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R8
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 3'd7) |=> (out_data == '0)); // R6
  AST_RSVD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_size == 3'd7) |-> (!size_ok && sel_word == '0)); // R6
  AST_MLO_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b00 && in_size != 3'd7) |=> (out_data[0] == $past(src_a[0]))); // R1
  AST_MHI_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && in_size != 3'd7) |=> (out_data[0] == $past(src_a[REG_W/2]))); // R2
  AST_MHI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b01 && in_size != 3'd7) |=> (out_data[REG_W-1] == $past(src_b[REG_W-1]))); // R2
  AST_PLO_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b10 && in_size != 3'd7) |=> (out_data[0] == $past(src_a[0]))); // R3
  AST_PHI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 2'b11 && in_size != 3'd7) |=> (out_data[REG_W-1] == $past(src_b[REG_W-1]))); // R4
endmodule

bind fieldmix_unit fm_checker #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_size   (in_size),
  .src_a     (src_a),
  .src_b     (src_b),
  .out_valid (out_valid),
  .out_data  (out_data),
  .sel_word  (sel_word),
  .size_ok   (size_ok)
);

// File: tb/fieldmix_unit_tb.sv
`timescale 1ns/1ps
module fieldmix_unit_tb;
  localparam int W = 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   in_op = 2'b00;
  logic [2:0]   in_size = 3'd0;
  logic [W-1:0] src_a = '0;
  logic [W-1:0] src_b = '0;
  logic         out_valid;
  logic [W-1:0] out_data;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fieldmix_unit #(.REG_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_size(in_size), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .out_data(out_data)
  );

  // Reference: for each result field, find which joined-word field feeds it.
  function automatic logic [W-1:0] model(input logic [1:0] op, input int k,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] j;
    logic [W-1:0]   r;
    int fw, nf, idx;
    if (k > 6) return '0;
    j  = {b, a};
    fw = 1 << k;
    nf = W / fw;
    r  = '0;
    for (int f = 0; f < nf; f++) begin
      case (op)
        2'b00: idx = (f % 2 == 0) ? f / 2 : nf + f / 2;
        2'b01: idx = (f % 2 == 0) ? nf / 2 + f / 2 : nf + nf / 2 + f / 2;
        2'b10: idx = 2 * f;
        default: idx = 2 * f + 1;
      endcase
      for (int t = 0; t < fw; t++) r[f * fw + t] = j[idx * fw + t];
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [2:0] sz,
                        input logic [W-1:0] a, input logic [W-1:0] b,
                        output logic [W-1:0] r, output logic v);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_size = sz; src_a = a; src_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    r = out_data;
    v = out_valid;
  endtask

  initial begin
    logic [W-1:0] r, r2, pl, ph, a, b, held;
    logic v;
    string tag;

    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 valid in reset", {127'd0, out_valid}, '0);
    check("R9 data in reset", out_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 valid after reset", {127'd0, out_valid}, '0);
    check("R9 data after reset", out_data, '0);

    // R1-style sweep: every size, every operation, several patterns
    for (int k = 0; k < 7; k++) begin
      for (int op = 0; op < 4; op++) begin
        for (int p = 0; p < 6; p++) begin
          case (p)
            0: begin a = '1; b = '0; end
            1: begin a = '0; b = '1; end
            2: begin a = {32{4'h5}}; b = {32{4'hC}}; end
            default: begin a = rnd128(); b = rnd128(); end
          endcase
          run_op(2'(op), 3'(k), a, b, r, v);
          case (op)
            0: tag = "R1 low interleave";
            1: tag = "R2 high interleave";
            2: tag = "R3 even gather";
            default: tag = "R4 odd gather";
          endcase
          check($sformatf("%s R5 size %0d", tag, k), r, model(2'(op), k, a, b));
          check("R7 valid after request", {127'd0, v}, {127'd0, 1'b1});
        end
      end
    end

    // R6: reserved size code gives zero with valid
    for (int op = 0; op < 4; op++) begin
      run_op(2'(op), 3'd7, rnd128() | 128'd1, '1, r, v);
      check("R6 reserved size zero", r, '0);
      check("R6 reserved size valid", {127'd0, v}, {127'd0, 1'b1});
    end

    // R8 and R7: idle cycles with changing inputs leave result stable, no valid
    a = rnd128(); b = rnd128();
    run_op(2'b01, 3'd3, a, b, held, v);
    for (int i = 0; i < 3; i++) begin
      in_op = 2'(i); in_size = 3'(i); src_a = rnd128(); src_b = rnd128();
      @(negedge clk);
      check("R8 hold while idle", out_data, held);
      check("R7 no valid while idle", {127'd0, out_valid}, '0);
    end

    // R10: gather then interleave restores the sources at every size
    for (int k = 0; k < 7; k++) begin
      a = rnd128(); b = rnd128();
      run_op(2'b10, 3'(k), a, b, pl, v);
      run_op(2'b11, 3'(k), a, b, ph, v);
      run_op(2'b00, 3'(k), pl, ph, r, v);
      check($sformatf("R10 round trip a size %0d", k), r, a);
      run_op(2'b01, 3'(k), pl, ph, r, v);
      check($sformatf("R10 round trip b size %0d", k), r, b);
    end

    // Back-to-back requests: R3 then R4 on consecutive cycles, different sizes
    for (int k = 0; k < 6; k++) begin
      a = rnd128(); b = rnd128();
      @(negedge clk);
      in_valid = 1'b1; in_op = 2'b10; in_size = 3'(k); src_a = a; src_b = b;
      @(negedge clk);
      r = out_data;
      in_op = 2'b11; in_size = 3'(k + 1);
      @(negedge clk);
      in_valid = 1'b0;
      r2 = out_data;
      check("R3 back-to-back first", r, model(2'b10, k, a, b));
      check("R4 back-to-back second", r2, model(2'b11, k + 1, a, b));
      check("R7 back-to-back valid", {127'd0, out_valid}, {127'd0, 1'b1});
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule